// File: doc/BRIEF.md
# Encoder Position Counter Channel with Byte-Wide Register Access

This block is one channel of a 24-bit position counter that a host reaches over an 8-bit bus. The bus has two ports, chosen by `bus_ctrl`. Writing the control port issues a command. Bits 7:5 of that byte select the target: 000 runs a reset/load action, 001 writes the count mode, 010 writes the input/interrupt setup, and 011 writes the index setup. Reading the control port returns the status flags.

The data port goes through a three-state byte pointer. The states are `PTR_LO`, `PTR_MID` and `PTR_HI`. Each data access takes the transitions `PTR_LO -> PTR_MID -> PTR_HI -> PTR_LO`, and the reset-pointer command forces the pointer back to `PTR_LO`. Data writes fill the preset register and data reads return the output latch, least significant byte first in both cases. The counter itself is loaded only from the preset. It is read only by a command that snapshots it into the latch.

A separate quadrature decoder supplies single-cycle count-up and count-down pulses. The block applies them according to one of four count modes; in two of those modes the preset acts as the ceiling. An index input can reload the counter from the preset. A one-cycle interrupt pulse reports a selectable event. The block also holds a prescaler byte for an external input filter.

Top module: `enc_chan_regs`

## Requirements
- R1: After reset the flag byte reads 0, data reads return 0, `flt_div` and `irq_out` are 0, and count pulses are ignored because counting is disabled.
- R2: Data-port writes store bytes into the preset at the pointer position, low byte first. After the third byte the pointer wraps to the low byte. A reset/load byte with bit 0 set returns the pointer to the low byte.
- R3: Reset/load bits 4:3 = 10 (for example 0x10) copy the counter into the output latch. Data-port reads return the latch low byte first, and each read advances the pointer. 0x11 does both the pointer reset and the latch copy.
- R4: The counter changes value only by counting, by reset/load bits 2:1 = 01 (0x02, which clears it), by bits 4:3 = 01 (0x08, which copies the preset into it), or by an index load. A data write alone never changes it.
- R5: In mode 0 (normal) the count wraps between 2^24-1 and 0. An up step from the top toggles flag bit 1 (carry). A down step from 0 toggles flag bit 0 (borrow).
- R6: In mode 1 (range limit), an up step at or above the preset holds the count and toggles carry. A down step at 0 holds the count and toggles borrow.
- R7: In mode 2 (non-recycle) the count wraps as in mode 0 and toggles the flag. It then ignores all count pulses until the counter is cleared or loaded.
- R8: In mode 3 (modulo-N), an up step at or above the preset wraps the count to 0 and toggles carry. A down step at 0 loads the preset and toggles borrow.
- R9: Flag bit 5 is 1 after an up step and 0 after a down step. Flag bit 4 (error) is set when up and down pulses arrive together, and the count does not move. Only reset/load bits 2:1 = 11 (0x06) clear the error flag. Bits 2:1 = 10 (0x04) clear borrow, carry and compare (bit 2) but leave the error flag set.
- R10: Input-setup bit 0 enables counting. While it is 0, count pulses change neither the count nor the flags.
- R11: Index setup bit 1 selects the active index edge: 1 means rising, 0 means falling. When input-setup bit 1 is 0, the active index edge loads the preset into the counter. When that bit is 1, the index edge has no effect on the count.
- R12: Input-setup bits 4:3 pick the event that drives `irq_out` for one cycle, starting at the clock edge where the event happens: 0 carry, 1 compare (a count step lands on the preset), 2 carry or borrow, 3 active index edge.
- R13: Reset/load bits 4:3 = 11 (0x18) copy the preset low byte to `flt_div`.
- R14: Control bytes with bits 7:5 at 100 or above do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; advances the pointer on data-port reads |
| bus_ctrl | input | 1 | 1 selects the control/flag port, 0 the data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (flags or a latch byte), valid in the access cycle |
| cnt_up | input | 1 | Count-up pulse from the decoder |
| cnt_dn | input | 1 | Count-down pulse from the decoder |
| index_in | input | 1 | Index signal, synchronous to `clk` |
| irq_out | output | 1 | One-cycle interrupt pulse |
| flt_div | output | 8 | Prescaler byte for the input filter |

## Verification
A wrong pointer state shows up at the very next data access, as a byte in the wrong lane of the preset or the latch. This is why the sweeps always read all three bytes. A wrong count, wrap point or halt state is hidden until the next latch command, so the bench snapshots and reads the counter after every pulse. A mode error is therefore caught within one count step. A flag toggled once too often or too rarely shows up directly on the control-port read that follows. The interrupt pulse is sampled in the cycle right after the edge that caused it.

// File: rtl/enc_chan_pkg.sv
package enc_chan_pkg;
    localparam int CNT_W   = 24;
    localparam int BUS_W   = 8;
    localparam int NBYTES  = CNT_W / BUS_W;

    typedef enum logic [1:0] {
        PTR_LO  = 2'd0,
        PTR_MID = 2'd1,
        PTR_HI  = 2'd2
    } ptr_e;

    localparam logic [2:0] TGT_RLD  = 3'b000;
    localparam logic [2:0] TGT_MODE = 3'b001;
    localparam logic [2:0] TGT_IOC  = 3'b010;
    localparam logic [2:0] TGT_IDX  = 3'b011;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_RANGE   = 2'd1,
        MODE_NORECYC = 2'd2,
        MODE_MODN    = 2'd3
    } cmode_e;

    typedef enum logic [1:0] {
        IRQ_CARRY = 2'd0,
        IRQ_CMP   = 2'd1,
        IRQ_CB    = 2'd2,
        IRQ_INDEX = 2'd3
    } isel_e;
endpackage

// File: rtl/enc_byte_ptr.sv
module enc_byte_ptr
    import enc_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    output ptr_e ptr_o
);
    ptr_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PTR_LO;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = PTR_LO;
        end else if (step_i) begin
            unique case (st_q)
                PTR_LO:  st_d = PTR_MID;
                PTR_MID: st_d = PTR_HI;
                PTR_HI:  st_d = PTR_LO;
                default: st_d = PTR_LO;
            endcase
        end
    end

    assign ptr_o = st_q;

    p_ptr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q == PTR_LO));
    p_ptr_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !step_i) |=> $stable(st_q));
endmodule

// File: rtl/enc_ctrl_decode.sv
module enc_ctrl_decode
    import enc_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic             rst_ptr_o,
    output logic             clr_cnt_o,
    output logic             clr_flags_o,
    output logic             clr_err_o,
    output logic             ld_cnt_o,
    output logic             ld_latch_o,
    output logic             ld_psc_o,
    output cmode_e           mode_o,
    output logic             cnt_en_o,
    output logic             idx_ld_en_o,
    output isel_e            isel_o,
    output logic             idx_pos_o
);
    logic [2:0] tgt;
    assign tgt = wdata_i[7:5];

    always_comb begin
        rst_ptr_o   = 1'b0;
        clr_cnt_o   = 1'b0;
        clr_flags_o = 1'b0;
        clr_err_o   = 1'b0;
        ld_cnt_o    = 1'b0;
        ld_latch_o  = 1'b0;
        ld_psc_o    = 1'b0;
        if (wr_i && tgt == TGT_RLD) begin
            rst_ptr_o = wdata_i[0];
            case (wdata_i[2:1])
                2'b01:   clr_cnt_o   = 1'b1;
                2'b10:   clr_flags_o = 1'b1;
                2'b11:   clr_err_o   = 1'b1;
                default: ;
            endcase
            case (wdata_i[4:3])
                2'b01:   ld_cnt_o   = 1'b1;
                2'b10:   ld_latch_o = 1'b1;
                2'b11:   ld_psc_o   = 1'b1;
                default: ;
            endcase
        end
    end

    logic idx_ld_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o     <= MODE_NORMAL;
            cnt_en_o   <= 1'b0;
            idx_ld_n_q <= 1'b0;
            isel_o     <= IRQ_CARRY;
            idx_pos_o  <= 1'b0;
        end else if (wr_i) begin
            case (tgt)
                TGT_MODE: mode_o <= cmode_e'(wdata_i[2:1]);
                TGT_IOC: begin
                    cnt_en_o   <= wdata_i[0];
                    idx_ld_n_q <= wdata_i[1];
                    isel_o     <= isel_e'(wdata_i[4:3]);
                end
                TGT_IDX:  idx_pos_o <= wdata_i[1];
                default: ;
            endcase
        end
    end

    assign idx_ld_en_o = ~idx_ld_n_q;

    p_cfg_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[7]) |=> ($stable(mode_o) && $stable(cnt_en_o) && $stable(isel_o)));
endmodule

// File: rtl/enc_count_core.sv
module enc_count_core
    import enc_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic             idx_i,
    input  logic             en_i,
    input  cmode_e           mode_i,
    input  logic             idx_ld_en_i,
    input  logic             idx_pos_i,
    input  isel_e            isel_i,
    input  logic             clr_cnt_i,
    input  logic             ld_cnt_i,
    input  logic             clr_flags_i,
    input  logic             clr_err_i,
    input  logic [CNT_W-1:0] preset_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [BUS_W-1:0] flags_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic idx_q, halt_q, bt_q, ct_q, cmp_q, err_q, dir_q;
    logic idx_edge, idx_load, overide, step_up, step_dn, conflict;
    logic carry_ev, borrow_ev, cmp_ev;

    assign idx_edge = idx_pos_i ? (idx_i & ~idx_q) : (~idx_i & idx_q);
    assign idx_load = idx_edge & idx_ld_en_i;
    assign overide  = clr_cnt_i | ld_cnt_i | idx_load;
    assign step_up  = en_i & up_i & ~dn_i & ~halt_q & ~overide;
    assign step_dn  = en_i & dn_i & ~up_i & ~halt_q & ~overide;
    assign conflict = en_i & up_i & dn_i;

    always_comb begin
        cnt_d     = cnt_q;
        carry_ev  = 1'b0;
        borrow_ev = 1'b0;
        if (step_up) begin
            unique case (mode_i)
                MODE_NORMAL, MODE_NORECYC: begin
                    carry_ev = (cnt_q == CNT_MAX);
                    cnt_d    = cnt_q + 1'b1;
                end
                MODE_RANGE: begin
                    carry_ev = (cnt_q >= preset_i);
                    if (!carry_ev) cnt_d = cnt_q + 1'b1;
                end
                MODE_MODN: begin
                    carry_ev = (cnt_q >= preset_i);
                    cnt_d    = carry_ev ? '0 : cnt_q + 1'b1;
                end
                default: ;
            endcase
        end else if (step_dn) begin
            borrow_ev = (cnt_q == '0);
            unique case (mode_i)
                MODE_NORMAL, MODE_NORECYC: cnt_d = cnt_q - 1'b1;
                MODE_RANGE: if (!borrow_ev) cnt_d = cnt_q - 1'b1;
                MODE_MODN:  cnt_d = borrow_ev ? preset_i : cnt_q - 1'b1;
                default: ;
            endcase
        end
        if (clr_cnt_i)                 cnt_d = '0;
        else if (ld_cnt_i || idx_load) cnt_d = preset_i;
    end

    assign cmp_ev = (step_up | step_dn) && (cnt_d == preset_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= 1'b0;
            halt_q <= 1'b0;
            bt_q   <= 1'b0;
            ct_q   <= 1'b0;
            cmp_q  <= 1'b0;
            err_q  <= 1'b0;
            dir_q  <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            idx_q <= idx_i;
            if (overide)
                halt_q <= 1'b0;
            else if (mode_i == MODE_NORECYC && (carry_ev || borrow_ev))
                halt_q <= 1'b1;
            if (clr_flags_i) begin
                bt_q  <= 1'b0;
                ct_q  <= 1'b0;
                cmp_q <= 1'b0;
            end else begin
                bt_q  <= bt_q ^ borrow_ev;
                ct_q  <= ct_q ^ carry_ev;
                cmp_q <= cmp_q | cmp_ev;
            end
            if (clr_err_i)     err_q <= 1'b0;
            else if (conflict) err_q <= 1'b1;
            if (step_up)      dir_q <= 1'b1;
            else if (step_dn) dir_q <= 1'b0;
            unique case (isel_i)
                IRQ_CARRY: irq_o <= carry_ev;
                IRQ_CMP:   irq_o <= cmp_ev;
                IRQ_CB:    irq_o <= carry_ev | borrow_ev;
                IRQ_INDEX: irq_o <= idx_edge;
                default:   irq_o <= 1'b0;
            endcase
        end
    end

    assign cnt_o   = cnt_q;
    assign flags_o = {2'b00, dir_q, err_q, 1'b0, cmp_q, ct_q, bt_q};

    p_hold_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_cnt_i && !ld_cnt_i && !idx_load) |=> $stable(cnt_q));
    p_range_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_RANGE && en_i && up_i && !dn_i && cnt_q == preset_i && !overide)
        |=> (cnt_q == $past(preset_i)));
    p_modn_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_MODN && en_i && up_i && !dn_i && !halt_q && cnt_q == preset_i && !overide)
        |=> (cnt_q == '0));
    p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && !overide) |=> $stable(cnt_q));
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr_err_i) |=> err_q);
endmodule

// File: rtl/enc_chan_regs.sv
module enc_chan_regs
    import enc_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_ctrl,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             cnt_up,
    input  logic             cnt_dn,
    input  logic             index_in,
    output logic             irq_out,
    output logic [BUS_W-1:0] flt_div
);
    logic ctrl_wr, data_wr, data_rd;
    assign ctrl_wr = bus_wr & bus_ctrl;
    assign data_wr = bus_wr & ~bus_ctrl;
    assign data_rd = bus_rd & ~bus_ctrl;

    logic rst_ptr, clr_cnt, clr_flags, clr_err, ld_cnt, ld_latch, ld_psc;
    logic cnt_en, idx_ld_en, idx_pos;
    cmode_e mode;
    isel_e  isel;
    ptr_e   ptr;

    logic [CNT_W-1:0] preset_q, latch_q, cnt;
    logic [BUS_W-1:0] flags, psc_q;

    enc_ctrl_decode u_dec (
        .clk(clk), .rst_n(rst_n), .wr_i(ctrl_wr), .wdata_i(bus_wdata),
        .rst_ptr_o(rst_ptr), .clr_cnt_o(clr_cnt), .clr_flags_o(clr_flags),
        .clr_err_o(clr_err), .ld_cnt_o(ld_cnt), .ld_latch_o(ld_latch),
        .ld_psc_o(ld_psc), .mode_o(mode), .cnt_en_o(cnt_en),
        .idx_ld_en_o(idx_ld_en), .isel_o(isel), .idx_pos_o(idx_pos)
    );

    enc_byte_ptr u_ptr (
        .clk(clk), .rst_n(rst_n), .clr_i(rst_ptr),
        .step_i(data_wr | data_rd), .ptr_o(ptr)
    );

    enc_count_core u_core (
        .clk(clk), .rst_n(rst_n), .up_i(cnt_up), .dn_i(cnt_dn),
        .idx_i(index_in), .en_i(cnt_en), .mode_i(mode),
        .idx_ld_en_i(idx_ld_en), .idx_pos_i(idx_pos), .isel_i(isel),
        .clr_cnt_i(clr_cnt), .ld_cnt_i(ld_cnt), .clr_flags_i(clr_flags),
        .clr_err_i(clr_err), .preset_i(preset_q), .cnt_o(cnt),
        .flags_o(flags), .irq_o(irq_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preset_q <= '0;
            latch_q  <= '0;
            psc_q    <= '0;
        end else begin
            if (data_wr) begin
                unique case (ptr)
                    PTR_LO:  preset_q[BUS_W-1:0]         <= bus_wdata;
                    PTR_MID: preset_q[2*BUS_W-1:BUS_W]   <= bus_wdata;
                    PTR_HI:  preset_q[3*BUS_W-1:2*BUS_W] <= bus_wdata;
                    default: ;
                endcase
            end
            if (ld_latch) latch_q <= cnt;
            if (ld_psc)   psc_q   <= preset_q[BUS_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_ctrl) begin
            bus_rdata = flags;
        end else begin
            unique case (ptr)
                PTR_LO:  bus_rdata = latch_q[BUS_W-1:0];
                PTR_MID: bus_rdata = latch_q[2*BUS_W-1:BUS_W];
                PTR_HI:  bus_rdata = latch_q[3*BUS_W-1:2*BUS_W];
                default: bus_rdata = '0;
            endcase
        end
    end

    assign flt_div = psc_q;

    p_latch_only_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_latch |=> $stable(latch_q));
    p_preset_only_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> $stable(preset_q));
    p_psc_only_cmd_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_psc |=> $stable(psc_q));
endmodule

// File: tb/enc_chan_regs_tb.sv
module enc_chan_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] MAXV = 24'hFFFFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, bus_ctrl = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic cnt_up = 1'b0, cnt_dn = 1'b0, index_in = 1'b0;
    logic irq_out;
    logic [7:0] flt_div;

    int checks = 0;
    int errors = 0;
    logic last_irq;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    enc_chan_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_ctrl(bus_ctrl), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_up(cnt_up), .cnt_dn(cnt_dn), .index_in(index_in),
        .irq_out(irq_out), .flt_div(flt_div)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic ctrl_w(input logic [7:0] b);
        bus_wr = 1'b1; bus_ctrl = 1'b1; bus_wdata = b;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic data_w(input logic [7:0] b);
        bus_wr = 1'b1; bus_ctrl = 1'b0; bus_wdata = b;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic data_r(output logic [7:0] b);
        bus_rd = 1'b1; bus_ctrl = 1'b0;
        #1 b = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic flags_r(output logic [7:0] b);
        bus_rd = 1'b1; bus_ctrl = 1'b1;
        #1 b = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic write_preset(input logic [23:0] v);
        ctrl_w(8'h01);
        data_w(v[7:0]); data_w(v[15:8]); data_w(v[23:16]);
    endtask

    task automatic read_count(output logic [23:0] v);
        logic [7:0] b0, b1, b2;
        ctrl_w(8'h11);
        data_r(b0); data_r(b1); data_r(b2);
        v = {b2, b1, b0};
    endtask

    task automatic pulse(input logic up, input logic dn);
        cnt_up = up; cnt_dn = dn;
        tick();
        last_irq = irq_out;
        cnt_up = 1'b0; cnt_dn = 1'b0;
    endtask

    // Model from the requirements: returns {event, next count}
    function automatic logic [24:0] m_step(input logic [1:0] md, input logic up,
                                           input logic [23:0] c, input logic [23:0] p);
        if (up) begin
            case (md)
                2'd1:    return (c >= p) ? {1'b1, c} : {1'b0, c + 24'd1};
                2'd3:    return (c >= p) ? {1'b1, 24'd0} : {1'b0, c + 24'd1};
                default: return (c == MAXV) ? {1'b1, 24'd0} : {1'b0, c + 24'd1};
            endcase
        end else begin
            case (md)
                2'd1:    return (c == 0) ? {1'b1, 24'd0} : {1'b0, c - 24'd1};
                2'd3:    return (c == 0) ? {1'b1, p} : {1'b0, c - 24'd1};
                default: return (c == 0) ? {1'b1, MAXV} : {1'b0, c - 24'd1};
            endcase
        end
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic [23:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1 reset state
        flags_r(b);   chk("R1 flags", b, 8'h00);
        data_r(b);    chk("R1 data", b, 8'h00);
        chk("R1 flt_div", flt_div, 8'h00);
        chk("R1 irq", irq_out, 1'b0);
        pulse(1'b1, 1'b0); pulse(1'b1, 1'b0);
        read_count(v); chk("R1 disabled count", v, 24'h0);

        // R2/R3 byte order and latch
        write_preset(24'hABCDEF);
        read_count(v); chk("R4 preset write alone", v, 24'h0);
        ctrl_w(8'h08);
        read_count(v); chk("R3 latch read order", v, 24'hABCDEF);
        ctrl_w(8'h01);
        data_w(8'h11); data_w(8'h22); data_w(8'h33); data_w(8'h44);
        ctrl_w(8'h08);
        read_count(v); chk("R2 pointer wrap", v, 24'h332244);
        ctrl_w(8'h02);
        read_count(v); chk("R4 clear counter", v, 24'h0);

        // R13 prescaler
        write_preset(24'h123456);
        ctrl_w(8'h18);
        chk("R13 prescaler", flt_div, 8'h56);

        // R14 unused targets
        ctrl_w(8'h08);
        ctrl_w(8'hE2); ctrl_w(8'h9A); ctrl_w(8'hA1);
        read_count(v); chk("R14 ignored target", v, 24'h123456);

        // R5-R8 sweep over modes, directions
        for (int md = 0; md < 4; md++) begin
            for (int d = 0; d < 2; d++) begin
                logic [23:0] p, c, st;
                logic [24:0] r;
                logic bt, ct, halted;
                string tag;
                p = 24'd5;
                if (d == 1) st = (md == 1 || md == 3) ? p - 24'd3 : MAXV - 24'd2;
                else        st = 24'd2;
                ctrl_w(8'h20 | 8'(md << 1));
                ctrl_w(8'h41);
                write_preset(st); ctrl_w(8'h08);
                write_preset(p);
                ctrl_w(8'h04);
                c = st; bt = 1'b0; ct = 1'b0; halted = 1'b0;
                tag = (md == 0) ? "R5" : (md == 1) ? "R6" : (md == 2) ? "R7" : "R8";
                for (int s = 0; s < 6; s++) begin
                    pulse(d == 1, d == 0);
                    if (!halted) begin
                        r = m_step(2'(md), d == 1, c, p);
                        c = r[23:0];
                        if (r[24]) begin
                            if (d == 1) ct = ~ct; else bt = ~bt;
                            if (md == 2) halted = 1'b1;
                        end
                    end
                    read_count(v); chk({tag, " count"}, v, c);
                    flags_r(b);
                    chk({tag, " carry/borrow"}, b[1:0], {ct, bt});
                    chk("R9 direction", b[5], (d == 1));
                end
            end
        end

        // R9 error flag
        ctrl_w(8'h20); ctrl_w(8'h41);
        write_preset(24'd100); ctrl_w(8'h08);
        pulse(1'b1, 1'b1);
        read_count(v); chk("R9 conflict no move", v, 24'd100);
        flags_r(b); chk("R9 error set", b[4], 1'b1);
        ctrl_w(8'h04);
        flags_r(b); chk("R9 flag clear keeps error", b[4], 1'b1);
        ctrl_w(8'h06);
        flags_r(b); chk("R9 error cleared", b[4], 1'b0);

        // R10 disable
        ctrl_w(8'h40);
        pulse(1'b1, 1'b0); pulse(1'b0, 1'b1); pulse(1'b1, 1'b0);
        read_count(v); chk("R10 disabled count", v, 24'd100);
        flags_r(b); chk("R10 disabled flags", b[1:0], 2'b00);

        // R12 carry irq in normal mode
        ctrl_w(8'h41);
        write_preset(MAXV); ctrl_w(8'h08);
        write_preset(24'd3);
        pulse(1'b1, 1'b0); chk("R12 carry irq", last_irq, 1'b1);
        pulse(1'b1, 1'b0); chk("R12 no irq on plain step", last_irq, 1'b0);
        // compare irq: count 1 -> 2 -> 3 hits preset 3
        ctrl_w(8'h49);
        pulse(1'b1, 1'b0); chk("R12 compare not yet", last_irq, 1'b0);
        pulse(1'b1, 1'b0); chk("R12 compare irq", last_irq, 1'b1);
        flags_r(b); chk("R12 compare flag", b[2], 1'b1);
        // carry-or-borrow: down from 0
        ctrl_w(8'h02); ctrl_w(8'h51);
        pulse(1'b0, 1'b1); chk("R12 borrow irq", last_irq, 1'b1);

        // R11 index loads
        ctrl_w(8'h62);
        write_preset(24'h0A0B0C);
        ctrl_w(8'h02);
        ctrl_w(8'h59);
        index_in = 1'b1; tick();
        chk("R12 index irq", irq_out, 1'b1);
        read_count(v); chk("R11 rising index load", v, 24'h0A0B0C);
        ctrl_w(8'h02);
        index_in = 1'b0; tick();
        read_count(v); chk("R11 falling edge ignored when positive", v, 24'h0);
        ctrl_w(8'h60);
        index_in = 1'b1; tick(); index_in = 1'b0; tick();
        read_count(v); chk("R11 falling index load", v, 24'h0A0B0C);
        ctrl_w(8'h02);
        ctrl_w(8'h5B);
        index_in = 1'b1; tick(); index_in = 1'b0; tick();
        read_count(v); chk("R11 index load disabled", v, 24'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule